// File: doc/BRIEF.md
# Disk Task File Register Bank

This block holds the byte-wide addressing registers of a disk-style command interface: sector count, sector number, the two cylinder bytes and the drive/head byte. A host reaches them through a pair of active-low chip selects, a 3-bit register address and separate read and write strobes. Each strobe is one access, and registers move on data bits 7..0 only.

From the stored bytes the bank keeps a registered decoded view. In block-address mode this is a 28-bit logical block address. In cylinder mode it is a cylinder, head and sector tuple. The bank also gives the transfer length, with a count of zero expanded to 256, and a flag that says whether the drive-select bit matches the unit number this device has been given. A write to the command address is not stored. It leaves the bank as a one-cycle strobe with the written byte, for the command engine that sits downstream.

Top module: `tf_bank`

## Requirements
- R1: A register access happens only when `cs_lo_n`=0 and `cs_hi_n`=1. In that case, addresses 2, 3, 4, 5 and 6 select sector count, sector number, cylinder low, cylinder high and drive/head. A write stores `wdata`, and a read with `rd_en`=1 returns the stored byte on `rdata` in the same cycle.
- R2: Drive/head always reads back with bit 7 and bit 5 set to 1. Its other bits read back as written: bit 6 is the mode flag, bit 4 the drive select and bits 3..0 the head.
- R3: When drive/head bit 6 is 1, `lba_mode`=1 and `lba_out` = {drive/head[3:0], cylinder high, cylinder low, sector number}, with the sector number in bits 7..0. `cyl_out`, `head_out` and `sec_out` are then 0.
- R4: When drive/head bit 6 is 0, `lba_mode`=0, `cyl_out` = {cylinder high, cylinder low}, `head_out` = drive/head[3:0] and `sec_out` = sector number. `lba_out` is then 0.
- R5: `selected` is 1 exactly when drive/head bit 4 equals `unit_id`. It is registered, so it follows a change of either one at the next clock edge.
- R6: `cnt_out` equals the sector count register, except that a value of 0 gives 256.
- R7: Every decoded output reflects a write on the clock edge that samples the write strobe.
- R8: Reset clears every register to 0 and sets drive/head to A0h. After reset, `lba_mode`=0 and `cnt_out`=256.
- R9: `rdata` is 0 in these cases: for addresses 0, 1 and 7, when the chip selects are not in the register-access pattern, and when `rd_en` is 0.
- R10: A write to address 7 gives `cmd_stb`=1 for exactly one cycle after the sampling edge, with `cmd_byte` equal to the written byte. It leaves the stored registers unchanged.
- R11: No register changes on any of these writes: a write to address 0 or 1, or a write made while the chip selects are not in the register-access pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_lo_n | input | 1 | Lower chip select, active low |
| cs_hi_n | input | 1 | Upper chip select, active low |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| unit_id | input | 1 | Configured unit number |
| rdata | output | 8 | Read byte |
| cmd_stb | output | 1 | Command write pulse |
| cmd_byte | output | 8 | Byte written to the command address |
| lba_mode | output | 1 | 1 = block address view valid |
| selected | output | 1 | Drive select matches unit number |
| lba_out | output | 28 | Logical block address |
| cyl_out | output | 16 | Cylinder number |
| head_out | output | 4 | Head number |
| sec_out | output | 8 | Sector number |
| cnt_out | output | 9 | Transfer length in sectors, 1..256 |

## Verification
A corrupted stored byte shows up two ways. It appears on `rdata` in the same cycle as a read of its address. It also appears in the decoded outputs one edge after the write that should have set it, because those outputs are registered from the next-state values. An address decode error makes a byte land in the wrong field: a later readback of its neighbour, or the position of the byte inside `lba_out`, exposes it straight away. A wrong mode or select bit shows as the other interpretation being zeroed, or as `selected` taking the wrong value, within one cycle.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int TF_DW   = 8;
  localparam int TF_AW   = 3;
  localparam int TF_NREG = 5;
  localparam int TF_BASE = 2;

  typedef enum logic [TF_AW-1:0] {
    TF_A_DATA = 3'd0,
    TF_A_FEAT = 3'd1,
    TF_A_CNT  = 3'd2,
    TF_A_SEC  = 3'd3,
    TF_A_CLO  = 3'd4,
    TF_A_CHI  = 3'd5,
    TF_A_DH   = 3'd6,
    TF_A_CMD  = 3'd7
  } tf_addr_e;

  localparam int TF_I_CNT = 0;
  localparam int TF_I_SEC = 1;
  localparam int TF_I_CLO = 2;
  localparam int TF_I_CHI = 3;
  localparam int TF_I_DH  = 4;

  localparam logic [TF_DW-1:0] TF_DH_FIXED = 8'hA0;
endpackage

// File: rtl/tf_decode.sv
module tf_decode
  import tf_pkg::*;
#(
  parameter int AW   = TF_AW,
  parameter int NREG = TF_NREG,
  parameter int BASE = TF_BASE
) (
  input  logic            cs_lo_n,
  input  logic            cs_hi_n,
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  output logic [NREG-1:0] reg_we,
  output logic [NREG-1:0] reg_re,
  output logic            cmd_we
);
  logic tf_active;
  assign tf_active = !cs_lo_n && cs_hi_n;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [AW-1:0] RA = AW'(BASE + i);
    assign reg_we[i] = wr_en && tf_active && (addr == RA);
    assign reg_re[i] = rd_en && tf_active && (addr == RA);
  end

  assign cmd_we = wr_en && tf_active && (addr == TF_A_CMD);
endmodule

// File: rtl/tf_regs.sv
module tf_regs
  import tf_pkg::*;
#(
  parameter int DW   = TF_DW,
  parameter int NREG = TF_NREG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         reg_we,
  input  logic [NREG-1:0]         reg_re,
  input  logic                    cmd_we,
  input  logic [DW-1:0]           wdata,
  output logic [NREG-1:0][DW-1:0] nxt,
  output logic [DW-1:0]           rdata,
  output logic                    cmd_stb,
  output logic [DW-1:0]           cmd_byte
);
  logic [NREG-1:0][DW-1:0] q;
  logic [DW-1:0]           cmd_byte_n;

  for (genvar i = 0; i < NREG; i++) begin : g_nxt
    localparam logic [DW-1:0] FIX = (i == TF_I_DH) ? TF_DH_FIXED : '0;
    assign nxt[i] = reg_we[i] ? (wdata | FIX) : q[i];
  end

  assign cmd_byte_n = cmd_we ? wdata : cmd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) q[i] <= (i == TF_I_DH) ? TF_DH_FIXED : '0;
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) if (reg_we[i]) q[i] <= nxt[i];
      cmd_stb <= cmd_we;
      if (cmd_we) cmd_byte <= cmd_byte_n;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) if (reg_re[i]) rdata = rdata | q[i];
  end

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(cmd_we)); // R10
  AST_CMD_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && reg_we == '0) |=> $stable(q)); // R10
endmodule

// File: rtl/tf_xlate.sv
module tf_xlate
  import tf_pkg::*;
#(
  parameter int DW   = TF_DW,
  parameter int NREG = TF_NREG,
  parameter int HW   = 4,
  parameter int LW   = 3 * DW + HW,
  parameter int CW   = DW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0][DW-1:0] nxt,
  input  logic                    unit_id,
  output logic                    lba_mode,
  output logic                    selected,
  output logic [LW-1:0]           lba_out,
  output logic [2*DW-1:0]         cyl_out,
  output logic [HW-1:0]           head_out,
  output logic [DW-1:0]           sec_out,
  output logic [CW-1:0]           cnt_out
);
  localparam int MODE_BIT = 6;
  localparam int DRV_BIT  = 4;

  logic              mode_n, sel_n;
  logic [LW-1:0]     lba_n;
  logic [2*DW-1:0]   cyl_n;
  logic [HW-1:0]     head_n;
  logic [DW-1:0]     sec_n;
  logic [CW-1:0]     cnt_n;

  always_comb begin
    mode_n = nxt[TF_I_DH][MODE_BIT];
    sel_n  = (nxt[TF_I_DH][DRV_BIT] == unit_id);
    lba_n  = '0;
    cyl_n  = '0;
    head_n = '0;
    sec_n  = '0;
    if (mode_n) begin
      lba_n = {nxt[TF_I_DH][HW-1:0], nxt[TF_I_CHI], nxt[TF_I_CLO], nxt[TF_I_SEC]};
    end else begin
      cyl_n  = {nxt[TF_I_CHI], nxt[TF_I_CLO]};
      head_n = nxt[TF_I_DH][HW-1:0];
      sec_n  = nxt[TF_I_SEC];
    end
    cnt_n = (nxt[TF_I_CNT] == '0) ? CW'(1 << DW) : {1'b0, nxt[TF_I_CNT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_mode <= 1'b0;
      selected <= 1'b0;
      lba_out  <= '0;
      cyl_out  <= '0;
      head_out <= '0;
      sec_out  <= '0;
      cnt_out  <= CW'(1 << DW);
    end else begin
      lba_mode <= mode_n;
      selected <= sel_n;
      lba_out  <= lba_n;
      cyl_out  <= cyl_n;
      head_out <= head_n;
      sec_out  <= sec_n;
      cnt_out  <= cnt_n;
    end
  end

  AST_LBA_HIDES_CHS: assert property (@(posedge clk) disable iff (!rst_n)
    lba_mode |-> (cyl_out == '0 && head_out == '0 && sec_out == '0)); // R3
  AST_CHS_HIDES_LBA: assert property (@(posedge clk) disable iff (!rst_n)
    !lba_mode |-> (lba_out == '0)); // R4
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_out != '0); // R6
  AST_SEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (selected == ($past(unit_id) == $past(nxt[TF_I_DH][DRV_BIT])))); // R5
endmodule

// File: rtl/tf_bank.sv
module tf_bank
  import tf_pkg::*;
#(
  parameter int DW   = TF_DW,
  parameter int AW   = TF_AW,
  parameter int NREG = TF_NREG,
  parameter int HW   = 4,
  parameter int LW   = 3 * DW + HW,
  parameter int CW   = DW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_lo_n,
  input  logic            cs_hi_n,
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic            unit_id,
  output logic [DW-1:0]   rdata,
  output logic            cmd_stb,
  output logic [DW-1:0]   cmd_byte,
  output logic            lba_mode,
  output logic            selected,
  output logic [LW-1:0]   lba_out,
  output logic [2*DW-1:0] cyl_out,
  output logic [HW-1:0]   head_out,
  output logic [DW-1:0]   sec_out,
  output logic [CW-1:0]   cnt_out
);
  logic [NREG-1:0]         reg_we, reg_re;
  logic                    cmd_we;
  logic [NREG-1:0][DW-1:0] nxt;

  tf_decode #(.AW(AW), .NREG(NREG), .BASE(TF_BASE)) u_dec (
    .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en),
    .reg_we(reg_we), .reg_re(reg_re), .cmd_we(cmd_we)
  );

  tf_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .cmd_we(cmd_we), .wdata(wdata), .nxt(nxt), .rdata(rdata),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte)
  );

  tf_xlate #(.DW(DW), .NREG(NREG), .HW(HW), .LW(LW), .CW(CW)) u_xl (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .unit_id(unit_id),
    .lba_mode(lba_mode), .selected(selected), .lba_out(lba_out),
    .cyl_out(cyl_out), .head_out(head_out), .sec_out(sec_out), .cnt_out(cnt_out)
  );

  AST_DH_READ_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !cs_lo_n && cs_hi_n && addr == TF_A_DH) |-> (rdata[7] && rdata[5])); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || cs_lo_n || !cs_hi_n) |-> (rdata == '0)); // R9
  AST_SEC_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cs_lo_n && cs_hi_n && addr == TF_A_SEC) |=>
      ((lba_mode ? lba_out[DW-1:0] : sec_out) == $past(wdata))); // R7
  AST_BAD_CS_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_n || !cs_hi_n) |=> !cmd_stb); // R11
endmodule

// File: tb/sim_tf_bank.sv
module sim_tf_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_lo_n, cs_hi_n, rd_en, wr_en, unit_id;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata, cmd_byte, sec_out;
  logic        cmd_stb, lba_mode, selected;
  logic [27:0] lba_out;
  logic [15:0] cyl_out;
  logic [3:0]  head_out;
  logic [8:0]  cnt_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tf_bank u0 (
    .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .unit_id(unit_id),
    .rdata(rdata), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .lba_mode(lba_mode),
    .selected(selected), .lba_out(lba_out), .cyl_out(cyl_out), .head_out(head_out),
    .sec_out(sec_out), .cnt_out(cnt_out)
  );

  // stimulus table: {address, byte}
  localparam logic [10:0] VEC [8] = '{
    {3'd2, 8'h5A}, {3'd3, 8'hC3}, {3'd4, 8'h0F}, {3'd5, 8'hF0},
    {3'd6, 8'h00}, {3'd6, 8'h5F}, {3'd2, 8'hFF}, {3'd4, 8'h81}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d,
                    input logic lo = 1'b0, input logic hi = 1'b1);
    @(negedge clk);
    cs_lo_n = lo; cs_hi_n = hi; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cs_lo_n = 1'b1; cs_hi_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d,
                    input logic lo = 1'b0, input logic hi = 1'b1);
    cs_lo_n = lo; cs_hi_n = hi; addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0; cs_lo_n = 1'b1; cs_hi_n = 1'b1;
    #1;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; cs_lo_n = 1'b1; cs_hi_n = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0; unit_id = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 lba_mode", lba_mode, 0);
    chk("R8 cnt_out", cnt_out, 256);
    for (int a = 2; a < 6; a++) begin rd(3'(a), d); chk("R8 reg zero", d, 0); end
    rd(3'd6, d); chk("R8 drive/head A0", d, 8'hA0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 selected after reset", selected, 1);

    // R1 R2 table walk
    for (int i = 0; i < 8; i++) begin
      logic [2:0] a;
      logic [7:0] v;
      a = VEC[i][10:8]; v = VEC[i][7:0];
      wr(a, v);
      rd(a, d);
      chk(a == 3'd6 ? "R2 dh readback" : "R1 readback", d, (a == 3'd6) ? (v | 8'hA0) : v);
    end

    // R4 CHS
    wr(3'd3, 8'h11); wr(3'd4, 8'h34); wr(3'd5, 8'h12); wr(3'd6, 8'hA5);
    chk("R4 mode", lba_mode, 0);
    chk("R4 cyl", cyl_out, 16'h1234);
    chk("R4 head", head_out, 4'h5);
    chk("R4 sec", sec_out, 8'h11);
    chk("R4 lba zero", lba_out, 0);

    // R3 LBA
    wr(3'd6, 8'h49);
    chk("R3 mode", lba_mode, 1);
    chk("R3 lba", lba_out, 28'h9123411);
    chk("R3 chs zero", {cyl_out, head_out, sec_out}, 0);
    rd(3'd6, d); chk("R2 dh fixed bits", d, 8'hE9);

    // R7 latency
    wr(3'd3, 8'h77);
    chk("R7 sector seen next edge", lba_out[7:0], 8'h77);

    // R6 count
    wr(3'd2, 8'h00); chk("R6 zero is 256", cnt_out, 256);
    wr(3'd2, 8'h05); chk("R6 five", cnt_out, 5);
    wr(3'd2, 8'hFF); chk("R6 max", cnt_out, 255);

    // R5 unit select
    wr(3'd6, 8'h10);
    chk("R5 mismatch", selected, 0);
    unit_id = 1'b1;
    @(negedge clk);
    chk("R5 match", selected, 1);

    // R10 command
    wr(3'd7, 8'hEC);
    chk("R10 strobe", cmd_stb, 1);
    chk("R10 byte", cmd_byte, 8'hEC);
    @(negedge clk);
    chk("R10 one cycle", cmd_stb, 0);
    rd(3'd2, d); chk("R10 count kept", d, 8'hFF);

    // R11 ignored writes
    wr(3'd2, 8'h33, 1'b0, 1'b0); rd(3'd2, d); chk("R11 cs_hi low", d, 8'hFF);
    wr(3'd2, 8'h33, 1'b1, 1'b1); rd(3'd2, d); chk("R11 cs_lo high", d, 8'hFF);
    wr(3'd1, 8'h44); rd(3'd2, d); chk("R11 addr1 count", d, 8'hFF);
    rd(3'd3, d); chk("R11 addr1 sector", d, 8'h77);
    wr(3'd0, 8'h55); rd(3'd4, d); chk("R11 addr0 cyl lo", d, 8'h34);
    wr(3'd7, 8'h66, 1'b0, 1'b0);
    chk("R11 cmd bad cs", cmd_stb, 0);

    // R9 zero reads
    rd(3'd0, d); chk("R9 addr0", d, 0);
    rd(3'd1, d); chk("R9 addr1", d, 0);
    rd(3'd7, d); chk("R9 addr7", d, 0);
    rd(3'd2, d, 1'b0, 1'b0); chk("R9 bad cs", d, 0);
    cs_lo_n = 1'b0; cs_hi_n = 1'b1; addr = 3'd2; #1;
    chk("R9 no rd_en", rdata, 0);
    cs_lo_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule